// File: doc/BRIEF.md
# Quadrature Subcarrier Phase Generator

This block makes the digital phase references that drive a colour encoder's chroma modulators. A two-bit counter advances on every reference clock edge, so its four states repeat at one quarter of the reference rate. Two square waves are decoded from the counter a quarter period apart. The sine phase drives the U modulator, with +U taken as 0 degrees. The cosine phase drives the V modulator.

In PAL mode an inversion flag toggles on every one-cycle falling-sync strobe. The flag inverts the cosine phase, so the V carrier flips from one line to the next. In NTSC mode the flag is cleared and held at zero. While the burst gate is high, the block also drives two signed codes that give the direction of the colour burst. In NTSC the burst points along -U only. In PAL it is the sum of -U and a V part whose sign follows the inversion flag, so the burst swings between 135 and 225 degrees.

Top module: `subcarrier_quad_gen`

## Requirements
- R1: Reset (rst_n low, asynchronous) sets the phase state to 0 and clears v_inv. The phase state then advances by one, modulo 4, on every rising clock edge.
- R2: sin_ph is 1 in phase states 0 and 1, and 0 in states 2 and 3.
- R3: While v_inv is 0, cos_ph is 1 in phase states 3 and 0, and 0 in states 1 and 2. While v_inv is 1, cos_ph is the complement of that pattern.
- R4: In PAL mode (pal_mode = 1), each clock edge at which sync_fall is 1 toggles v_inv, and the new value is visible after that edge. Edges with sync_fall = 0 leave v_inv unchanged.
- R5: In NTSC mode (pal_mode = 0), v_inv is 0 after every clock edge, whatever sync_fall does.
- R6: While burst_gate is 0, burst_u and burst_v are both 2'b00, the code for zero.
- R7: While burst_gate is 1, burst_u is 2'b11, the two's-complement code for -1. In NTSC mode burst_v is 2'b00 at the same time.
- R8: While burst_gate is 1 in PAL mode, burst_v is 2'b01 (+1) when v_inv is 0 and 2'b11 (-1) when v_inv is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, four times the subcarrier rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| pal_mode | input | 1 | 1 selects PAL, 0 selects NTSC |
| sync_fall | input | 1 | One-cycle strobe for each falling sync edge |
| burst_gate | input | 1 | High during the colour burst window |
| sin_ph | output | 1 | Sine-phase carrier for the U modulator |
| cos_ph | output | 1 | Cosine-phase carrier for the V modulator, after inversion |
| v_inv | output | 1 | Current V-carrier inversion state |
| burst_u | output | 2 | Signed burst code for U |
| burst_v | output | 2 | Signed burst code for V |

## Verification
The block has no parameters, so the bench builds it exactly as it is used. The four phase states come round every four cycles. Random strobes on sync_fall, mixed with runs of back-to-back strobes, drive v_inv through both of its values while the counter is in each of its four states. The random switching between modes reaches the cycle where PAL changes to NTSC while v_inv is set, and a mid-run reset reaches the case where the counter and the flag are cleared while active.

// File: rtl/subcarrier_quad_gen.sv
module subcarrier_quad_gen (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pal_mode,
  input  logic       sync_fall,
  input  logic       burst_gate,
  output logic       sin_ph,
  output logic       cos_ph,
  output logic       v_inv,
  output logic [1:0] burst_u,
  output logic [1:0] burst_v
);

  logic [1:0] phase;
  logic       cos_raw;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) phase <= 2'd0;
    else        phase <= phase + 2'd1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         v_inv <= 1'b0;
    else if (!pal_mode) v_inv <= 1'b0;
    else if (sync_fall) v_inv <= ~v_inv;

  assign sin_ph  = ~phase[1];
  assign cos_raw = ~(phase[1] ^ phase[0]);
  assign cos_ph  = cos_raw ^ v_inv;

  assign burst_u = burst_gate ? 2'b11 : 2'b00;
  assign burst_v = (burst_gate && pal_mode) ? (v_inv ? 2'b11 : 2'b01) : 2'b00;

  // R2
  sin_follows_cos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> sin_ph == $past(cos_raw));

  // R4
  pal_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pal_mode && sync_fall) |=> v_inv != $past(v_inv));

  // R4
  pal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pal_mode && !sync_fall) |=> $stable(v_inv));

  // R5
  ntsc_no_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pal_mode |=> !v_inv);

  // R6
  gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !burst_gate |-> (burst_u == 2'b00 && burst_v == 2'b00));

  // R8
  pal_burst_v_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_gate && pal_mode) |-> $countones(burst_v) != 0);

endmodule

// File: tb/test_subcarrier_quad_gen.sv
module test_subcarrier_quad_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pal_mode = 1'b0, sync_fall = 1'b0, burst_gate = 1'b0;
  logic sin_ph, cos_ph, v_inv;
  logic [1:0] burst_u, burst_v;
  int n_run = 0, n_fail = 0;
  logic [1:0] m_ph;
  logic m_inv;

  always #5 clk = ~clk;

  subcarrier_quad_gen i_subcarrier_quad_gen (
    .clk(clk), .rst_n(rst_n), .pal_mode(pal_mode), .sync_fall(sync_fall),
    .burst_gate(burst_gate), .sin_ph(sin_ph), .cos_ph(cos_ph), .v_inv(v_inv),
    .burst_u(burst_u), .burst_v(burst_v));

  always @(posedge clk or negedge rst_n)
    if (!rst_n) begin m_ph <= 2'd0; m_inv <= 1'b0; end
    else begin
      m_ph  <= m_ph + 2'd1;
      m_inv <= pal_mode ? (m_inv ^ sync_fall) : 1'b0;
    end

  function automatic logic f_sin(logic [1:0] p); return (p == 2'd0 || p == 2'd1); endfunction
  function automatic logic f_cos(logic [1:0] p, logic inv); return (p == 2'd3 || p == 2'd0) ^ inv; endfunction
  function automatic logic [1:0] f_bu(logic g); return g ? 2'b11 : 2'b00; endfunction
  function automatic logic [1:0] f_bv(logic g, logic pal, logic inv);
    if (!g || !pal) return 2'b00;
    return inv ? 2'b11 : 2'b01;
  endfunction

  task automatic check(logic ok, string req, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_all();
    check(sin_ph == f_sin(m_ph), "R2 sin_ph", sin_ph, f_sin(m_ph));
    check(cos_ph == f_cos(m_ph, m_inv), "R3 cos_ph", cos_ph, f_cos(m_ph, m_inv));
    check(v_inv == m_inv, pal_mode ? "R4 v_inv" : "R5 v_inv", v_inv, m_inv);
    check(burst_u == f_bu(burst_gate), burst_gate ? "R7 burst_u" : "R6 burst_u", burst_u, f_bu(burst_gate));
    check(burst_v == f_bv(burst_gate, pal_mode, m_inv),
          pal_mode ? "R8 burst_v" : "R7 burst_v", burst_v, f_bv(burst_gate, pal_mode, m_inv));
  endtask

  task automatic step(logic pal, logic sf, logic g);
    pal_mode = pal; sync_fall = sf; burst_gate = g;
    @(negedge clk);
    check_all();
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd725));
    @(negedge clk);
    // R1 reset state
    check(sin_ph == 1'b1 && cos_ph == 1'b1, "R1 reset phase", {sin_ph, cos_ph}, 3);
    check(v_inv == 1'b0, "R1 reset v_inv", v_inv, 0);
    check(burst_u == 2'b00 && burst_v == 2'b00, "R6 reset burst", {burst_u, burst_v}, 0);
    rst_n = 1'b1;
    // R1 full phase cycle
    for (int k = 0; k < 8; k++) step(1'b0, 1'b0, 1'b0);
    // R4 back-to-back strobes in PAL
    for (int k = 0; k < 6; k++) step(1'b1, 1'b1, 1'b1);
    step(1'b1, 1'b0, 1'b1);
    // R5 NTSC ignores strobes, clears flag
    step(1'b1, 1'b1, 1'b1);
    for (int k = 0; k < 4; k++) step(1'b0, 1'b1, 1'b1);
    // R7 NTSC burst
    step(1'b0, 1'b0, 1'b1);
    check(burst_u == 2'b11 && burst_v == 2'b00, "R7 ntsc burst", {burst_u, burst_v}, 12);
    // random mix
    for (int k = 0; k < 3000; k++) begin
      logic pal;
      pal = ($urandom % 16 == 0) ? ~pal_mode : pal_mode;
      step(pal, ($urandom % 6) == 0, ($urandom % 3) != 0);
      if (k == 1500) begin
        pal_mode = 1'b1; sync_fall = 1'b1;
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check(v_inv == 1'b0 && sin_ph == 1'b1 && cos_ph == 1'b1, "R1 mid reset",
              {v_inv, sin_ph, cos_ph}, 3);
        @(negedge clk);
        rst_n = 1'b1;
      end
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule